// File: doc/BRIEF.md
# Multithreaded Reorder Buffer Commit Selector

This block decides, every cycle, which entries of a reorder buffer shared by several hardware threads are retired. Each buffer slot presents a valid bit, the owning thread number, an age ordinal (a smaller value is older; ages of valid entries are distinct and taken from a global counter that the buffer owner keeps from wrapping) and a completed flag. The selector returns one retire strobe per slot and a count of strobes. The buffer owner clears the strobed slots at the same clock edge.

An unfinished instruction holds back only the younger instructions of its own thread. Other threads keep retiring past it. Three policies can be selected. The cross-thread policy takes the oldest ready instructions from any mix of threads. The rotating policy serves one thread per cycle in turn. The oldest-owner policy serves only the thread that holds the oldest ready instruction. In every policy at most `W` strobes are raised in a cycle (default 8).

All selection logic is combinational from the slot inputs. The only state is the rotation pointer. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure: the buffer owner samples the strobes each cycle.

Top module: `rob_commit_sel`

## Requirements
- R1: After reset the rotation pointer `rr_turn` is 0, and with no valid slot no strobe is raised.
- R2: A strobe is raised only for a slot whose valid and completed bits are both set. If no slot is both valid and completed, `retire` is all zero.
- R3: Program order holds per thread. A slot retires only if every older valid slot of the same thread is completed and retires in the same cycle.
- R4: A slot that is valid but not completed blocks only younger slots of its own thread. Ready slots of other threads are still retired.
- R5: At most `W` strobes are raised per cycle. In cross-thread mode these are the `W` oldest eligible slots across all threads.
- R6: With `mode` = 1 (rotating), only slots of thread `rr_turn` retire. If that thread has nothing eligible, no strobe is raised in that cycle.
- R7: `rr_turn` steps by one modulo `T` on every clock edge taken while `mode` = 1, and holds its value in the other modes.
- R8: With `mode` = 2 (oldest-owner), only the thread owning the oldest eligible slot retires, up to its `W` oldest eligible slots.
- R9: `mode` = 0 and `mode` = 3 both select the cross-thread policy.
- R10: `retire_count` equals the number of set bits in `retire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0/3 cross-thread, 1 rotating, 2 oldest-owner |
| ent_valid | input | N | Slot holds an instruction |
| ent_tid | input | N*$clog2(T) | Thread of slot i at bits [i*TW +: TW] |
| ent_age | input | N*AW | Age of slot i at bits [i*AW +: AW]; smaller is older |
| ent_done | input | N | Slot has completed execution |
| retire | output | N | Retire strobe per slot |
| retire_count | output | $clog2(W+1) | Number of strobes this cycle |
| rr_turn | output | $clog2(T) | Thread served by the rotating policy |

## Verification
The checker asserts these rules on every cycle: the strobe limit, that only completed slots retire, that retirement within a thread never skips an older slot, that single-thread modes never mix threads, that the rotating mode follows `rr_turn`, and the stepping and holding of the pointer. Whether the chosen slots are exactly the oldest `W` eligible ones, and which thread the oldest-owner mode picks, can only be shown by the bench. It compares each cycle against its own scan of the buffer in age order. The bench also shows that a blocked thread does not stall the others, and it drains a random buffer while switching modes.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    MODE_ALL    = 2'd0,
    MODE_ROTATE = 2'd1,
    MODE_OLDEST = 2'd2,
    MODE_ALT    = 2'd3
  } mode_e;
endpackage

// File: rtl/rcs_ready_chain.sv
// Per-slot eligibility: completed and not behind an unfinished slot of the same thread.
module rcs_ready_chain #(
  parameter int N  = 16,
  parameter int TW = 2,
  parameter int AW = 8
) (
  input  logic [N-1:0]    valid,
  input  logic [N*TW-1:0] tid,
  input  logic [N*AW-1:0] age,
  input  logic [N-1:0]    done,
  output logic [N-1:0]    elig
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic stalled;
    always_comb begin
      stalled = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && valid[j] && !done[j] &&
            tid[j*TW +: TW] == tid[i*TW +: TW] &&
            age[j*AW +: AW] < age[i*AW +: AW])
          stalled = 1'b1;
      end
    end
    assign elig[i] = valid[i] & done[i] & ~stalled;
  end
endmodule

// File: rtl/rcs_thread_pick.sv
// Chooses the single thread served in the reduced-complexity modes.
module rcs_thread_pick #(
  parameter int N  = 16,
  parameter int T  = 4,
  parameter int TW = 2,
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rcs_pkg::mode_e       mode,
  input  logic [N-1:0]         elig,
  input  logic [N*TW-1:0]      tid,
  input  logic [N*AW-1:0]      age,
  output logic [TW-1:0]        turn,
  output logic [TW-1:0]        sel_tid,
  output logic                 one_thread
);
  import rcs_pkg::*;
  localparam logic [TW-1:0] LAST = TW'(T - 1);

  logic [N-1:0]  first;
  logic [TW-1:0] oldest_tid;

  for (genvar i = 0; i < N; i++) begin : g_first
    logic beaten;
    always_comb begin
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && elig[j] && age[j*AW +: AW] < age[i*AW +: AW])
          beaten = 1'b1;
    end
    assign first[i] = elig[i] & ~beaten;
  end

  always_comb begin
    oldest_tid = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) oldest_tid = oldest_tid | tid[i*TW +: TW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      turn <= '0;
    else if (mode == MODE_ROTATE)
      turn <= (turn == LAST) ? '0 : turn + 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_ROTATE: begin sel_tid = turn;       one_thread = 1'b1; end
      MODE_OLDEST: begin sel_tid = oldest_tid; one_thread = 1'b1; end
      default:     begin sel_tid = '0;         one_thread = 1'b0; end
    endcase
  end
endmodule

// File: rtl/rcs_slot_limit.sv
// Keeps the W oldest candidates and counts them.
module rcs_slot_limit #(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic [N-1:0]              cand,
  input  logic [N*AW-1:0]           age,
  output logic [N-1:0]              take,
  output logic [$clog2(W+1)-1:0]    count
);
  localparam int CW = $clog2(N + 1);
  localparam int KW = $clog2(W + 1);
  localparam logic [CW-1:0] LIMIT = CW'(W);

  for (genvar i = 0; i < N; i++) begin : g_rank
    logic [CW-1:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < N; j++)
        if (j != i && cand[j] && age[j*AW +: AW] < age[i*AW +: AW])
          rank = rank + 1'b1;
    end
    assign take[i] = cand[i] && (rank < LIMIT);
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++)
      count = count + KW'(take[i]);
  end
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel #(
  parameter int N  = 16,
  parameter int T  = 4,
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    mode,
  input  logic [N-1:0]                  ent_valid,
  input  logic [N*$clog2(T)-1:0]        ent_tid,
  input  logic [N*AW-1:0]               ent_age,
  input  logic [N-1:0]                  ent_done,
  output logic [N-1:0]                  retire,
  output logic [$clog2(W+1)-1:0]        retire_count,
  output logic [$clog2(T)-1:0]          rr_turn
);
  localparam int TW = $clog2(T);

  rcs_pkg::mode_e mode_q;
  logic [N-1:0]   elig;
  logic [N-1:0]   cand;
  logic [TW-1:0]  sel_tid;
  logic           one_thread;

  assign mode_q = rcs_pkg::mode_e'(mode);

  rcs_ready_chain #(.N(N), .TW(TW), .AW(AW)) u_chain (
    .valid(ent_valid), .tid(ent_tid), .age(ent_age), .done(ent_done), .elig(elig)
  );

  rcs_thread_pick #(.N(N), .T(T), .TW(TW), .AW(AW)) u_pick (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .elig(elig), .tid(ent_tid),
    .age(ent_age), .turn(rr_turn), .sel_tid(sel_tid), .one_thread(one_thread)
  );

  for (genvar i = 0; i < N; i++) begin : g_filter
    assign cand[i] = elig[i] & (~one_thread | (ent_tid[i*TW +: TW] == sel_tid));
  end

  rcs_slot_limit #(.N(N), .W(W), .AW(AW)) u_limit (
    .cand(cand), .age(ent_age), .take(retire), .count(retire_count)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int N  = 16,
  parameter int T  = 4,
  parameter int W  = 8,
  parameter int AW = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 mode,
  input logic [N-1:0]               ent_valid,
  input logic [N*$clog2(T)-1:0]     ent_tid,
  input logic [N*AW-1:0]            ent_age,
  input logic [N-1:0]               ent_done,
  input logic [N-1:0]               retire,
  input logic [$clog2(W+1)-1:0]     retire_count,
  input logic [$clog2(T)-1:0]       rr_turn
);
  localparam int TW = $clog2(T);

  AST_STROBE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(retire) <= W); // R5

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_count) == $countones(retire)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((ent_valid & ent_done) == '0) |-> (retire == '0)); // R2

  AST_TURN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (int'(rr_turn) == (int'($past(rr_turn)) + 1) % T)); // R7

  AST_TURN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd1) |=> $stable(rr_turn)); // R7

  for (genvar i = 0; i < N; i++) begin : g_i
    AST_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      retire[i] |-> (ent_valid[i] && ent_done[i])); // R2

    AST_ROTATE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && retire[i]) |-> (ent_tid[i*TW +: TW] == rr_turn)); // R6

    for (genvar j = 0; j < N; j++) begin : g_j
      if (i != j) begin : g_pair
        AST_THREAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
          (retire[i] && ent_valid[j] &&
           ent_tid[j*TW +: TW] == ent_tid[i*TW +: TW] &&
           ent_age[j*AW +: AW] < ent_age[i*AW +: AW]) |-> retire[j]); // R3

        AST_SINGLE_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
          ((mode == 2'd1 || mode == 2'd2) && retire[i] && retire[j])
            |-> (ent_tid[i*TW +: TW] == ent_tid[j*TW +: TW])); // R8
      end
    end
  end
endmodule

bind rob_commit_sel rcs_checker #(.N(N), .T(T), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ent_valid(ent_valid), .ent_tid(ent_tid),
  .ent_age(ent_age), .ent_done(ent_done), .retire(retire),
  .retire_count(retire_count), .rr_turn(rr_turn)
);

// File: tb/rob_commit_sel_test.sv
module rob_commit_sel_test;
  localparam int N  = 16;
  localparam int T  = 4;
  localparam int W  = 8;
  localparam int AW = 8;
  localparam int TW = 2;
  localparam int KW = $clog2(W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = '0;
  logic [N-1:0]      ent_valid = '0;
  logic [N*TW-1:0]   ent_tid = '0;
  logic [N*AW-1:0]   ent_age = '0;
  logic [N-1:0]      ent_done = '0;
  logic [N-1:0]      retire;
  logic [KW-1:0]     retire_count;
  logic [TW-1:0]     rr_turn;

  always #10 clk = ~clk;

  rob_commit_sel #(.N(N), .T(T), .W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ent_valid(ent_valid), .ent_tid(ent_tid),
    .ent_age(ent_age), .ent_done(ent_done), .retire(retire),
    .retire_count(retire_count), .rr_turn(rr_turn)
  );

  int checks = 0;
  int errors = 0;
  int exp_turn = 0;

  bit m_valid[N];
  bit m_done[N];
  int m_tid[N];
  int m_age[N];

  typedef struct {
    logic [N-1:0] mask;
    int           cnt;
    int           turn;
    string        tag;
  } exp_t;
  exp_t q[$];

  // Reference: walk the buffer in age order, blocking a thread at its first unfinished slot.
  task automatic ref_model(input int md, input int turn, output logic [N-1:0] m, output int cnt);
    bit blocked[T];
    logic [N-1:0] el;
    int owner;
    el = '0; owner = -1; m = '0; cnt = 0;
    for (int t = 0; t < T; t++) blocked[t] = 0;
    for (int a = 0; a < (1 << AW); a++)
      for (int i = 0; i < N; i++)
        if (m_valid[i] && m_age[i] == a) begin
          if (!m_done[i]) blocked[m_tid[i]] = 1;
          else if (!blocked[m_tid[i]]) begin
            el[i] = 1'b1;
            if (owner < 0) owner = m_tid[i];
          end
        end
    for (int a = 0; a < (1 << AW); a++)
      for (int i = 0; i < N; i++)
        if (el[i] && m_age[i] == a && cnt < W) begin
          if (md == 0 || md == 3 || (md == 1 && m_tid[i] == turn) ||
              (md == 2 && m_tid[i] == owner)) begin
            m[i] = 1'b1; cnt++;
          end
        end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_done[i] = 0; m_tid[i] = 0; m_age[i] = 0;
    end
  endtask

  task automatic put(input int idx, input int t, input int a, input bit d);
    m_valid[idx] = 1; m_tid[idx] = t; m_age[idx] = a; m_done[idx] = d;
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic step(input int md, input string tag);
    logic [N-1:0] em;
    int ec;
    @(negedge clk);
    mode = 2'(md);
    for (int i = 0; i < N; i++) begin
      ent_valid[i] = m_valid[i];
      ent_done[i]  = m_done[i];
      ent_tid[i*TW +: TW] = TW'(m_tid[i]);
      ent_age[i*AW +: AW] = AW'(m_age[i]);
    end
    ref_model(md, exp_turn, em, ec);
    q.push_back('{em, ec, exp_turn, tag});
    @(posedge clk);
    if (md == 1) exp_turn = (exp_turn + 1) % T;
    for (int i = 0; i < N; i++) if (em[i]) m_valid[i] = 0;
  endtask

  // Monitor: compare away from the active edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #8;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (retire !== e.mask) begin
          errors++;
          $display("FAIL %s retire actual=%h expected=%h", e.tag, retire, e.mask);
        end
        checks++;
        if (int'(retire_count) != e.cnt) begin // R10
          errors++;
          $display("FAIL R10 retire_count actual=%0d expected=%0d", retire_count, e.cnt);
        end
        checks++;
        if (int'(rr_turn) != e.turn) begin // R7
          errors++;
          $display("FAIL R7 rr_turn actual=%0d expected=%0d", rr_turn, e.turn);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty buffer after reset
    step(0, "R1");

    // R2: valid but nothing completed
    clear_all();
    for (int i = 0; i < 6; i++) put(i, i % T, i, 0);
    step(0, "R2");

    // R3/R4: thread 0 stalled at age 1, thread 1 keeps retiring
    clear_all();
    put(0, 0, 0, 1); put(1, 0, 1, 0); put(2, 0, 2, 1); put(3, 0, 3, 1);
    put(4, 1, 4, 1); put(5, 1, 5, 1); put(6, 1, 6, 1);
    step(0, "R4");
    step(0, "R3");

    // R5: twelve ready slots, only the eight oldest retire
    clear_all();
    for (int i = 0; i < 12; i++) put(i, i % T, 11 - i, 1);
    step(0, "R5");

    // R9: code 3 behaves as cross-thread
    clear_all();
    for (int i = 0; i < 12; i++) put(i, (i / 3) % T, i * 2, 1);
    step(3, "R9");

    // R6/R7: rotation, including a turn whose thread has nothing ready
    clear_all();
    for (int i = 0; i < 9; i++) put(i, (i % 3 == 2) ? 3 : i % 3, i + 20, 1);
    m_done[8] = 0;
    for (int c = 0; c < 5; c++) step(1, "R6");
    step(0, "R7");

    // R8: oldest slot unfinished; owner of oldest ready slot is thread 1
    clear_all();
    put(0, 2, 0, 0); put(1, 1, 3, 1); put(2, 3, 5, 1); put(3, 1, 7, 1);
    put(4, 2, 1, 1); put(5, 0, 9, 1);
    step(2, "R8");
    step(2, "R8");

    // R3/R5/R10: random drain with mixed modes
    for (int r = 0; r < 4; r++) begin
      clear_all();
      for (int i = 0; i < N; i++)
        put(i, int'($urandom % T), (i * 7 + r * 5) % N + 30, bit'($urandom % 2));
      for (int c = 0; c < 25; c++) begin
        for (int i = 0; i < N; i++) if (!m_done[i]) m_done[i] = bit'($urandom % 3 == 0);
        step(int'($urandom % 4), "R3");
      end
    end

    @(negedge clk);
    #9;
    finish_run();
  end
endmodule